// File: doc/BRIEF.md
# Tightly-Coupled Memory Request Router

This block sits on a processor's data bus and steers every load and store (byte, halfword or word) to one of four targets: the boot ROM region, a local instruction-side scratch RAM, a local data-side scratch RAM, or the external bus. The windows of the two local RAMs come from configuration inputs, normally driven by the processor's system-control coprocessor. Those inputs are an enable and a size for the instruction window, which always starts at address zero, and an enable, a base and a size for the data window. The block decodes the same windows for every access width.

Window sizes are set at run time and may be larger than the RAM behind them. When that happens the RAM repeats through the window, because only the low offset bits index it. The instruction RAM is indexed by the low address bits. The data RAM is indexed by the low bits of the offset from its base. An access that lands in either RAM is served there in full and never appears on the external bus. Reads from a local RAM return one cycle later. The result is right-aligned and zero-extended. Writes go through per-byte enables.

Top module: `tcm_router`

## Requirements
- R1: Routing priority is ROM region, then instruction RAM, then data RAM, then external. While `req_valid` is high, exactly one `route` bit is set (bit 0 ROM, bit 1 instruction RAM, bit 2 data RAM, bit 3 external). While it is low, `route` is zero.
- R2: The instruction window hits only when it is enabled and the address is below `cfg_itcm_size`. A size of zero never hits.
- R3: The data window hits only when it is enabled and `cfg_dtcm_base <= addr < cfg_dtcm_base + cfg_dtcm_size`. An address one below the base, or equal to base plus size, misses.
- R4: The instruction RAM word is selected by address bits [ITCM_ABITS-1:2]. A window larger than the RAM therefore mirrors it.
- R5: The data RAM word is selected by bits [DTCM_ABITS-1:2] of (address − base). A window larger than the RAM therefore mirrors it.
- R6: An access routed to a local RAM or to the ROM region keeps `ext_valid` low. An external access drives `ext_valid` and passes through the address and the write flag unchanged.
- R7: Size encoding is 0 byte, 1 halfword, 2 word. A byte sets the enable for lane addr[1:0]. A halfword sets lanes {addr[1],0} and {addr[1],1}. A word sets all four lanes. Write data is replicated into every lane.
- R8: A read that hits a local RAM raises `rsp_valid` in the next cycle. The data is right-aligned and zero-extended (a byte takes lane addr[1:0], a halfword takes half addr[1]). No other access raises `rsp_valid`.
- R9: A local write changes only the bytes whose enables are set.
- R10: During reset and right after it, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_itcm_en | input | 1 | Instruction window enable |
| cfg_itcm_size | input | 32 | Instruction window size in bytes, from address 0 |
| cfg_dtcm_en | input | 1 | Data window enable |
| cfg_dtcm_base | input | 32 | Data window base address |
| cfg_dtcm_size | input | 32 | Data window size in bytes |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store value, right-aligned |
| route | output | 4 | One-hot target: ROM, ITCM, DTCM, external |
| rsp_valid | output | 1 | Local read data valid |
| rsp_rdata | output | 32 | Local read data, right-aligned |
| ext_valid | output | 1 | External bus request |
| ext_write | output | 1 | External store flag |
| ext_addr | output | 32 | External address |
| ext_be | output | 4 | External byte enables |
| ext_wdata | output | 32 | External store data, lane-replicated |

## Verification
The bench places the data window inside an oversized instruction window, and the ROM region next to the data window. A decoder that checks in the wrong order would then send those accesses to the wrong target. It probes addresses one below the base, at base plus size, and at the instruction size itself. An off-by-one compare would claim or drop the edge word. It writes through one alias of an oversized window and reads through another, which catches an index taken from the wrong bits. Sub-word stores and loads on a known word show any lane or enable mistake as corrupted neighbouring bytes or shifted results.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   localparam int RT_ROM  = 0;
   localparam int RT_ITCM = 1;
   localparam int RT_DTCM = 2;
   localparam int RT_EXT  = 3;
   localparam int RT_N    = 4;
   localparam int LANES   = 4;
endpackage

// File: rtl/tcm_window_dec.sv
module tcm_window_dec
   import tcm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DTCM_ABITS = 11,
   parameter int ROM_ABITS = 16,
   parameter logic [ADDR_W-1:0] ROM_BASE = '1
)(
   input  logic [ADDR_W-1:0]   addr,
   input  logic                itcm_en,
   input  logic [ADDR_W-1:0]   itcm_size,
   input  logic                dtcm_en,
   input  logic [ADDR_W-1:0]   dtcm_base,
   input  logic [ADDR_W-1:0]   dtcm_size,
   output logic [RT_N-1:0]     hit,
   output logic [DTCM_ABITS-3:0] dtcm_idx
);
   logic [ADDR_W-1:0] off;
   logic rom_raw, itcm_raw, dtcm_raw;

   always_comb begin
      off      = addr - dtcm_base;
      rom_raw  = addr[ADDR_W-1:ROM_ABITS] == ROM_BASE[ADDR_W-1:ROM_ABITS];
      itcm_raw = itcm_en && (addr < itcm_size);
      dtcm_raw = dtcm_en && (addr >= dtcm_base) && (off < dtcm_size);
      dtcm_idx = off[DTCM_ABITS-1:2];
      hit      = '0;
      if (rom_raw)       hit[RT_ROM]  = 1'b1;
      else if (itcm_raw) hit[RT_ITCM] = 1'b1;
      else if (dtcm_raw) hit[RT_DTCM] = 1'b1;
      else               hit[RT_EXT]  = 1'b1;
   end
endmodule

// File: rtl/tcm_lane.sv
module tcm_lane
   import tcm_pkg::*;
(
   input  logic [1:0]  wr_size,
   input  logic [1:0]  wr_a,
   input  logic [31:0] wr_val,
   output logic [3:0]  be,
   output logic [31:0] wr_lane,
   input  logic [1:0]  rd_size,
   input  logic [1:0]  rd_a,
   input  logic [31:0] rd_word,
   output logic [31:0] rd_val
);
   always_comb begin
      unique case (acc_size_e'(wr_size))
         SZ_BYTE: begin
            be      = 4'b0001 << wr_a;
            wr_lane = {4{wr_val[7:0]}};
         end
         SZ_HALF: begin
            be      = wr_a[1] ? 4'b1100 : 4'b0011;
            wr_lane = {2{wr_val[15:0]}};
         end
         default: begin
            be      = 4'b1111;
            wr_lane = wr_val;
         end
      endcase
   end

   always_comb begin
      unique case (acc_size_e'(rd_size))
         SZ_BYTE: rd_val = {24'd0, rd_word[8*rd_a +: 8]};
         SZ_HALF: rd_val = {16'd0, rd_word[16*rd_a[1] +: 16]};
         default: rd_val = rd_word;
      endcase
   end
endmodule

// File: rtl/tcm_ram.sv
module tcm_ram
   import tcm_pkg::*;
#(
   parameter int IDX_W = 10
)(
   input  logic             clk,
   input  logic             en,
   input  logic             we,
   input  logic [LANES-1:0] be,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata
);
   localparam int DEPTH = 1 << IDX_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (en && we && be[g]) mem[idx] <= wdata[8*g +: 8];
         if (en) rdata[8*g +: 8] <= mem[idx];
      end
   end
endmodule

// File: rtl/tcm_router.sv
module tcm_router
   import tcm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int ITCM_ABITS = 12,
   parameter int DTCM_ABITS = 11,
   parameter int ROM_ABITS = 16,
   parameter logic [ADDR_W-1:0] ROM_BASE = 32'hFFFF_0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_itcm_en,
   input  logic [ADDR_W-1:0] cfg_itcm_size,
   input  logic              cfg_dtcm_en,
   input  logic [ADDR_W-1:0] cfg_dtcm_base,
   input  logic [ADDR_W-1:0] cfg_dtcm_size,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic [3:0]        route,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              ext_valid,
   output logic              ext_write,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [3:0]        ext_be,
   output logic [31:0]       ext_wdata
);
   localparam int I_IDX_W = ITCM_ABITS - 2;
   localparam int D_IDX_W = DTCM_ABITS - 2;

   if (ITCM_ABITS < 3 || ITCM_ABITS > 20) begin : g_bad_itcm
      $error("ITCM_ABITS out of range");
   end
   if (DTCM_ABITS < 3 || DTCM_ABITS > 20) begin : g_bad_dtcm
      $error("DTCM_ABITS out of range");
   end
   if (ROM_ABITS < 2 || ROM_ABITS >= ADDR_W) begin : g_bad_rom
      $error("ROM_ABITS out of range");
   end

   logic [RT_N-1:0]    hit;
   logic [D_IDX_W-1:0] dtcm_idx;
   logic [3:0]         be;
   logic [31:0]        wr_lane;
   logic [31:0]        iq, dq;
   logic               rd_dtcm_q;
   logic [1:0]         rd_size_q, rd_a_q;
   logic               rsp_q;

   tcm_window_dec #(
      .ADDR_W(ADDR_W), .DTCM_ABITS(DTCM_ABITS),
      .ROM_ABITS(ROM_ABITS), .ROM_BASE(ROM_BASE)
   ) u_dec (
      .addr(req_addr), .itcm_en(cfg_itcm_en), .itcm_size(cfg_itcm_size),
      .dtcm_en(cfg_dtcm_en), .dtcm_base(cfg_dtcm_base), .dtcm_size(cfg_dtcm_size),
      .hit(hit), .dtcm_idx(dtcm_idx)
   );

   tcm_lane u_lane (
      .wr_size(req_size), .wr_a(req_addr[1:0]), .wr_val(req_wdata),
      .be(be), .wr_lane(wr_lane),
      .rd_size(rd_size_q), .rd_a(rd_a_q), .rd_word(rd_dtcm_q ? dq : iq),
      .rd_val(rsp_rdata)
   );

   assign route = req_valid ? hit : '0;

   tcm_ram #(.IDX_W(I_IDX_W)) u_itcm (
      .clk(clk), .en(route[RT_ITCM]), .we(req_write), .be(be),
      .idx(req_addr[ITCM_ABITS-1:2]), .wdata(wr_lane), .rdata(iq)
   );

   tcm_ram #(.IDX_W(D_IDX_W)) u_dtcm (
      .clk(clk), .en(route[RT_DTCM]), .we(req_write), .be(be),
      .idx(dtcm_idx), .wdata(wr_lane), .rdata(dq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q     <= 1'b0;
         rd_dtcm_q <= 1'b0;
         rd_size_q <= 2'd0;
         rd_a_q    <= 2'd0;
      end else begin
         rsp_q <= (route[RT_ITCM] | route[RT_DTCM]) & ~req_write;
         if (req_valid) begin
            rd_dtcm_q <= hit[RT_DTCM];
            rd_size_q <= req_size;
            rd_a_q    <= req_addr[1:0];
         end
      end
   end

   assign rsp_valid = rsp_q;
   assign ext_valid = route[RT_EXT];
   assign ext_write = req_write;
   assign ext_addr  = req_addr;
   assign ext_be    = be;
   assign ext_wdata = wr_lane;
endmodule

// File: rtl/tcm_router_chk.sv
module tcm_router_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic        cfg_itcm_en,
   input logic [3:0]  route,
   input logic        rsp_valid,
   input logic        ext_valid,
   input logic        ext_write,
   input logic [3:0]  ext_be
);
   // R1
   route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $countones(route) == 1);
   // R1
   route_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> route == 4'd0);
   // R2
   itcm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cfg_itcm_en) |-> !route[1]);
   // R6
   no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route[0] || route[1] || route[2]) |-> !ext_valid);
   // R7
   ext_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && ext_write) |-> ext_be != 4'd0);
   // R8
   rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write && (route[1] || route[2])));
   // R8
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && (route[1] || route[2])) |=> rsp_valid);
   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !rsp_valid);
endmodule

bind tcm_router tcm_router_chk u_chk (.*);

// File: tb/tcm_router_tb.sv
module tcm_router_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_itcm_en = 1'b0, cfg_dtcm_en = 1'b0;
   logic [31:0] cfg_itcm_size = '0, cfg_dtcm_base = '0, cfg_dtcm_size = '0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [3:0]  route, ext_be;
   logic        rsp_valid, ext_valid, ext_write;
   logic [31:0] rsp_rdata, ext_addr, ext_wdata;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   tcm_router u_dut (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(bit wr, logic [1:0] sz, logic [31:0] a, logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz;
      req_addr = a; req_wdata = wd;
      #1;
   endtask

   task automatic step();
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic wr(logic [1:0] sz, logic [31:0] a, logic [31:0] wd);
      put(1'b1, sz, a, wd);
      step();
   endtask

   task automatic rd_chk(string tag, logic [1:0] sz, logic [31:0] a,
                         logic [3:0] exp_rt, logic [31:0] exp_d);
      put(1'b0, sz, a, 32'd0);
      chk({tag, " route"}, {28'd0, route}, {28'd0, exp_rt});
      step();
      chk({tag, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
      chk({tag, " data"}, rsp_rdata, exp_d);
   endtask

   task automatic rt_chk(string tag, logic [31:0] a, logic [3:0] exp_rt);
      put(1'b0, 2'd2, a, 32'd0);
      chk(tag, {28'd0, route}, {28'd0, exp_rt});
      step();
   endtask

   task automatic t_reset();
      #1;
      chk("R10 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      chk("R1 idle route", {28'd0, route}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R10 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
   endtask

   task automatic t_itcm_basic();
      cfg_itcm_en = 1'b1; cfg_itcm_size = 32'h1000;
      put(1'b1, 2'd2, 32'h10, 32'hCAFE_F00D);
      chk("R6 itcm write not forwarded", {31'd0, ext_valid}, 32'd0);
      step();
      rd_chk("R2 itcm read", 2'd2, 32'h10, 4'b0010, 32'hCAFE_F00D);
      rt_chk("R2 itcm edge at size", 32'h1000, 4'b1000);
      rt_chk("R2 itcm last word", 32'h0FFC, 4'b0010);
   endtask

   task automatic t_itcm_zero();
      cfg_itcm_size = 32'h0;
      put(1'b0, 2'd2, 32'h10, 32'd0);
      chk("R2 size zero misses", {28'd0, route}, 32'b1000);
      chk("R6 miss forwarded", {31'd0, ext_valid}, 32'd1);
      chk("R6 ext addr", ext_addr, 32'h10);
      step();
      chk("R8 no rsp for external", {31'd0, rsp_valid}, 32'd0);
   endtask

   task automatic t_itcm_mirror();
      cfg_itcm_size = 32'h8000;
      wr(2'd2, 32'h1004, 32'h5A5A_1234);
      rd_chk("R4 mirror low", 2'd2, 32'h0004, 4'b0010, 32'h5A5A_1234);
      rd_chk("R4 mirror high", 2'd2, 32'h2004, 4'b0010, 32'h5A5A_1234);
   endtask

   task automatic t_dtcm();
      cfg_itcm_size = 32'h0;
      cfg_dtcm_en = 1'b1; cfg_dtcm_base = 32'h0080_0000; cfg_dtcm_size = 32'h4000;
      wr(2'd2, 32'h0080_0808, 32'h0102_0304);
      rd_chk("R5 dtcm mirror", 2'd2, 32'h0080_0008, 4'b0100, 32'h0102_0304);
      rt_chk("R3 below base", 32'h007F_FFFC, 4'b1000);
      rt_chk("R3 last word", 32'h0080_3FFC, 4'b0100);
      rt_chk("R3 at base plus size", 32'h0080_4000, 4'b1000);
      cfg_dtcm_en = 1'b0;
      rt_chk("R3 disabled", 32'h0080_0000, 4'b1000);
      cfg_dtcm_en = 1'b1;
   endtask

   task automatic t_priority();
      cfg_itcm_size = 32'h0100_0000;
      rt_chk("R1 itcm over dtcm", 32'h0080_0010, 4'b0010);
      cfg_dtcm_base = 32'hFFFE_0000; cfg_dtcm_size = 32'h0002_0000;
      rt_chk("R1 rom over dtcm", 32'hFFFF_0004, 4'b0001);
      put(1'b1, 2'd2, 32'hFFFF_0008, 32'h1);
      chk("R6 rom write not external", {31'd0, ext_valid}, 32'd0);
      step();
      rt_chk("R1 dtcm below rom", 32'hFFFE_FFFC, 4'b0100);
   endtask

   task automatic t_lanes();
      cfg_itcm_size = 32'h1000;
      wr(2'd2, 32'h20, 32'h1122_3344);
      wr(2'd0, 32'h21, 32'h0000_00AB);
      rd_chk("R9 byte write", 2'd2, 32'h20, 4'b0010, 32'h1122_AB44);
      wr(2'd1, 32'h22, 32'h0000_5566);
      rd_chk("R9 half write", 2'd2, 32'h20, 4'b0010, 32'h5566_AB44);
      rd_chk("R8 half read", 2'd1, 32'h22, 4'b0010, 32'h0000_5566);
      rd_chk("R8 byte read", 2'd0, 32'h21, 4'b0010, 32'h0000_00AB);
   endtask

   task automatic t_ext_be();
      cfg_itcm_en = 1'b0; cfg_dtcm_en = 1'b0;
      put(1'b1, 2'd0, 32'h0200_0003, 32'h0000_00EE);
      chk("R7 byte lane3 be", {28'd0, ext_be}, 32'b1000);
      chk("R7 byte data", ext_wdata, 32'hEEEE_EEEE);
      chk("R6 ext write", {31'd0, ext_write}, 32'd1);
      step();
      put(1'b1, 2'd0, 32'h0200_0001, 32'h0000_0077);
      chk("R7 byte lane1 be", {28'd0, ext_be}, 32'b0010);
      step();
      put(1'b1, 2'd1, 32'h0200_0002, 32'h0000_BEEF);
      chk("R7 half be", {28'd0, ext_be}, 32'b1100);
      chk("R7 half data", ext_wdata, 32'hBEEF_BEEF);
      step();
      put(1'b1, 2'd2, 32'h0200_0000, 32'h8765_4321);
      chk("R7 word be", {28'd0, ext_be}, 32'b1111);
      chk("R7 word data", ext_wdata, 32'h8765_4321);
      step();
   endtask

   initial begin
      t_reset();
      t_itcm_basic();
      t_itcm_zero();
      t_itcm_mirror();
      t_dtcm();
      t_priority();
      t_lanes();
      t_ext_be();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule